// File: doc/BRIEF.md
# Fast PWM Timer with Selectable TOP

A single-slope up-counter that drives pulse-width-modulated outputs. The counter climbs by one on each cycle where the external timer-clock enable is high. When it equals the current TOP value, it returns to zero on the following enabled cycle. A 4-bit mode code selects TOP: one of three fixed limits (8, 9 or 10 bits), the capture register, or the active value of compare channel 0. Every other code lets the counter run over the full width.

Each compare channel has its own 2-bit output mode. The output either rises at BOTTOM and falls after a match (non-inverting) or does the reverse (inverting). Writes to a compare register land in a buffer. The buffer moves into the active compare value only on the enabled cycle where the counter sits at TOP, so a period never mixes an old and a new duty value.

Overflow, capture and per-channel compare flags stay set until software writes a 1 to their bit. An already-qualified capture strobe from outside copies the counter into the capture register. Configuration goes through a write-only register bus:

| Address | Contents |
|---|---|
| 0 | Control word: mode in bits [3:0], channel i output mode in bits [4+2i+1:4+2i] |
| 1 | Capture register |
| 2 | Flag clear: bit0 overflow, bit1 capture, bit 2+i compare channel i |
| 4+i | Compare buffer of channel i |

Top module: `fpwm_timer`

## Requirements
- R1: On each clock with `tickEn` high the counter increments by one. When it already equals TOP, it goes to 0 instead. With `tickEn` low it holds. The full-width count wraps from all ones to 0.
- R2: TOP is 0x00FF for mode 5, 0x01FF for mode 6 and 0x03FF for mode 7. Mode 14 uses the capture register and mode 15 uses the active compare value of channel 0. Any other mode code uses all ones.
- R3: With output mode 2 (non-inverting), the channel output goes high as the counter returns to 0 and goes low on the enabled cycle where the counter equals the active compare value. For a compare value C below TOP, the output is high for C+1 counter values of each period.
- R4: Output mode 3 gives the complement of output mode 2. Output modes 0 and 1 drive the output low.
- R5: The overflow flag sets on the enabled cycle where the counter equals TOP. In mode 15 the channel-0 compare flag also sets on that cycle, and in mode 14 the capture flag also sets on that cycle.
- R6: A channel's compare flag sets on the enabled cycle where the counter equals its active compare value. A compare value above TOP never matches, and a non-inverting output then stays high for the whole period.
- R7: In modes 5, 6 and 7, bits of a written compare value above the 8-, 9- or 10-bit resolution are stored as zero.
- R8: A compare write changes only the buffer. The active compare value, including channel 0 when it is TOP, takes the buffer contents on the enabled cycle where the counter is at TOP.
- R9: A flag clears when a 1 is written to its bit at address 2, and other flags are untouched. A flag set condition in the same cycle wins over the clear.
- R10: Outside mode 14, a high `capEvent` copies the counter into the capture register and sets the capture flag. In mode 14, `capEvent` is ignored.
- R11: After reset the counter, capture register, compare values, control word and all flags are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Timer clock enable |
| capEvent | input | 1 | Qualified capture strobe |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | CNT_W (16) | Write data |
| cntVal | output | CNT_W (16) | Current counter value |
| capVal | output | CNT_W (16) | Capture register |
| pwmOut | output | NUM_CH (2) | Channel PWM outputs |
| ovfFlag | output | 1 | Overflow flag |
| capFlag | output | 1 | Capture flag |
| cmpFlag | output | NUM_CH (2) | Compare flags |

## Verification
The bench builds the block with its defaults, a 16-bit counter and two compare channels. These values make every fixed TOP reachable, as well as the 65536-count wrap for the unlisted mode codes. A capture-register TOP of 9 gives a ten-count period, short enough that duty cycles, compare values above TOP and compare values of zero can be counted sample by sample on both channels at once. With two channels, inverting and non-inverting outputs can be compared within the same period.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_FIX8   = 4'd5;
  localparam logic [MODE_W-1:0] MODE_FIX9   = 4'd6;
  localparam logic [MODE_W-1:0] MODE_FIX10  = 4'd7;
  localparam logic [MODE_W-1:0] MODE_CAPTOP = 4'd14;
  localparam logic [MODE_W-1:0] MODE_CMPTOP = 4'd15;

  // strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic              wrCap;
    logic              capEvt;
    logic [MODE_W-1:0] mode;
  } fpwmCmd_t;

  // events from datapath back to control
  typedef struct packed {
    logic topHit;
    logic capTaken;
  } fpwmEvt_t;
endpackage

// File: rtl/fpwm_datapath.sv
module fpwm_datapath
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fpwmCmd_t                      cmd,
  input  logic [NUM_CH-1:0]             wrCmp,
  input  logic [CNT_W-1:0]              wrData,
  output logic [CNT_W-1:0]              cnt,
  output logic [CNT_W-1:0]              capReg,
  output fpwmEvt_t                      evt,
  output logic [NUM_CH-1:0]             matchHit,
  output logic [NUM_CH-1:0]             phase
);
  localparam logic [CNT_W-1:0] LIM8  = CNT_W'(255);
  localparam logic [CNT_W-1:0] LIM9  = CNT_W'(511);
  localparam logic [CNT_W-1:0] LIM10 = CNT_W'(1023);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [NUM_CH-1:0][CNT_W-1:0] cmpBuf;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpAct;
  logic [CNT_W-1:0] topVal;
  logic [CNT_W-1:0] wrMask;
  logic atTop;
  logic topHit;
  logic capTake;

  // TOP selection and write mask, both driven by the mode code
  always_comb begin
    case (cmd.mode)
      MODE_FIX8:   begin topVal = LIM8;      wrMask = LIM8;  end
      MODE_FIX9:   begin topVal = LIM9;      wrMask = LIM9;  end
      MODE_FIX10:  begin topVal = LIM10;     wrMask = LIM10; end
      MODE_CAPTOP: begin topVal = capReg;    wrMask = '1;    end
      MODE_CMPTOP: begin topVal = cmpAct[0]; wrMask = '1;    end
      default:     begin topVal = '1;        wrMask = '1;    end
    endcase
  end

  assign atTop   = (cnt == topVal);
  assign topHit  = cmd.tick && atTop;
  assign capTake = cmd.capEvt && !cmd.wrCap && (cmd.mode != MODE_CAPTOP);

  always_comb begin
    evt.topHit   = topHit;
    evt.capTaken = capTake;
  end

  // single-slope counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.tick) begin
      if (atTop) cnt <= '0;
      else       cnt <= cnt + ONE;
    end
  end

  // capture register: bus write has priority over the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg <= '0;
    end else if (cmd.wrCap) begin
      capReg <= wrData;
    end else if (capTake) begin
      capReg <= cnt;
    end
  end

  // compare buffers and active values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpBuf <= '0;
      cmpAct <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrCmp[i]) cmpBuf[i] <= wrData & wrMask;
        if (topHit)   cmpAct[i] <= cmpBuf[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      matchHit[i] = cmd.tick && (cnt == cmpAct[i]);
    end
  end

  // waveform phase: high from BOTTOM until match; BOTTOM wins over a match at TOP
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (topHit)           phase[i] <= 1'b1;
        else if (matchHit[i]) phase[i] <= 1'b0;
      end
    end
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.tick |=> $stable(cnt));

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.topHit |=> (cnt == '0));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gChk
      // R8
      act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !evt.topHit |=> $stable(cmpAct[g]));

      // R3
      phase_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
        (matchHit[g] && !evt.topHit) |=> !phase[g]);
    end
  endgenerate
endmodule

// File: rtl/fpwm_ctrl.sv
module fpwm_ctrl
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               capEvent,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CNT_W-1:0]   busWdata,
  input  fpwmEvt_t           evt,
  input  logic [NUM_CH-1:0]  matchHit,
  input  logic [NUM_CH-1:0]  phase,
  output fpwmCmd_t           cmd,
  output logic [NUM_CH-1:0]  wrCmp,
  output logic [NUM_CH-1:0]  pwmOut,
  output logic               ovfFlag,
  output logic               capFlag,
  output logic [NUM_CH-1:0]  cmpFlag
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CAP  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(2);
  localparam int                CMP_BASE  = 4;
  localparam int                OM_LSB    = MODE_W;

  logic [MODE_W-1:0]       modeReg;
  logic [NUM_CH-1:0][1:0]  omReg;
  logic wrCtrl;
  logic clrHit;

  assign wrCtrl = busWe && (busAddr == ADDR_CTRL);
  assign clrHit = busWe && (busAddr == ADDR_CLR);

  always_comb begin
    cmd.tick   = tickEn;
    cmd.wrCap  = busWe && (busAddr == ADDR_CAP);
    cmd.capEvt = capEvent;
    cmd.mode   = modeReg;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gDec
      assign wrCmp[g] = busWe && (busAddr == ADDR_W'(CMP_BASE + g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      omReg   <= '0;
    end else if (wrCtrl) begin
      modeReg <= busWdata[MODE_W-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        omReg[i] <= busWdata[OM_LSB + 2*i +: 2];
      end
    end
  end

  // sticky flags, set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      capFlag <= 1'b0;
      cmpFlag <= '0;
    end else begin
      if (evt.topHit)                 ovfFlag <= 1'b1;
      else if (clrHit && busWdata[0]) ovfFlag <= 1'b0;

      if (evt.capTaken || (evt.topHit && modeReg == MODE_CAPTOP)) capFlag <= 1'b1;
      else if (clrHit && busWdata[1])                             capFlag <= 1'b0;

      for (int i = 0; i < NUM_CH; i++) begin
        if (matchHit[i] || (i == 0 && evt.topHit && modeReg == MODE_CMPTOP))
          cmpFlag[i] <= 1'b1;
        else if (clrHit && busWdata[2+i])
          cmpFlag[i] <= 1'b0;
      end
    end
  end

  // output polarity per channel
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      case (omReg[i])
        2'd2:    pwmOut[i] = phase[i];
        2'd3:    pwmOut[i] = ~phase[i];
        default: pwmOut[i] = 1'b0;
      endcase
    end
  end

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.topHit |=> ovfFlag);

  // R9
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(clrHit && busWdata[0])) |=> ovfFlag);

  // R10
  cap_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.capTaken |=> capFlag);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gFlagChk
      // R6
      cmp_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        matchHit[g] |=> cmpFlag[g]);
    end
  endgenerate
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              capEvent,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  capVal,
  output logic [NUM_CH-1:0] pwmOut,
  output logic              ovfFlag,
  output logic              capFlag,
  output logic [NUM_CH-1:0] cmpFlag
);
  fpwmCmd_t          cmd;
  fpwmEvt_t          evt;
  logic [NUM_CH-1:0] wrCmp;
  logic [NUM_CH-1:0] matchHit;
  logic [NUM_CH-1:0] phase;

  fpwm_ctrl #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capEvent(capEvent),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .evt(evt), .matchHit(matchHit), .phase(phase),
    .cmd(cmd), .wrCmp(wrCmp), .pwmOut(pwmOut),
    .ovfFlag(ovfFlag), .capFlag(capFlag), .cmpFlag(cmpFlag)
  );

  fpwm_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrCmp(wrCmp), .wrData(busWdata),
    .cnt(cntVal), .capReg(capVal), .evt(evt),
    .matchHit(matchHit), .phase(phase)
  );
endmodule

// File: tb/tb_fpwm_timer.sv
module tb_fpwm_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        capEvent = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] cntVal;
  logic [15:0] capVal;
  logic [1:0]  pwmOut;
  logic        ovfFlag;
  logic        capFlag;
  logic [1:0]  cmpFlag;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  fpwm_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capEvent(capEvent),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .cntVal(cntVal), .capVal(capVal), .pwmOut(pwmOut),
    .ovfFlag(ovfFlag), .capFlag(capFlag), .cmpFlag(cmpFlag)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 1'b0; capEvent = 1'b0; busWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic capPulse();
    @(negedge clk);
    capEvent = 1'b1;
    @(negedge clk);
    capEvent = 1'b0;
  endtask

  // sample outputs before each of n ticks, count high samples
  task automatic measure(input int n, output int hi0, output int hi1);
    hi0 = 0; hi1 = 0;
    for (int k = 0; k < n; k++) begin
      if (pwmOut[0]) hi0++;
      if (pwmOut[1]) hi1++;
      tick(1);
    end
  endtask

  function automatic logic [15:0] ctrlWord(input logic [3:0] m, input logic [1:0] o0, input logic [1:0] o1);
    return {8'd0, o1, o0, m};
  endfunction

  task automatic testReset();
    doReset();
    chk("R11", "counter", cntVal, 0);
    chk("R11", "capture", capVal, 0);
    chk("R11", "flags", {ovfFlag, capFlag, cmpFlag}, 0);
    chk("R11", "outputs", pwmOut, 0);
  endtask

  task automatic testFixedTops();
    doReset();
    wr(0, ctrlWord(4'd5, 2'd0, 2'd0));
    tick(100);
    chk("R1", "count 100", cntVal, 100);
    repeat (5) @(negedge clk);
    chk("R1", "hold without enable", cntVal, 100);
    tick(155);
    chk("R2", "mode5 at TOP", cntVal, 16'h00FF);
    chk("R5", "no overflow before TOP", ovfFlag, 0);
    tick(1);
    chk("R1", "mode5 wrap", cntVal, 0);
    chk("R5", "overflow at TOP", ovfFlag, 1);

    doReset();
    wr(0, ctrlWord(4'd6, 2'd0, 2'd0));
    tick(512);
    chk("R2", "mode6 period 512", cntVal, 0);
    chk("R5", "mode6 overflow", ovfFlag, 1);

    doReset();
    wr(0, ctrlWord(4'd7, 2'd0, 2'd0));
    tick(1023);
    chk("R2", "mode7 at TOP", cntVal, 16'h03FF);
    tick(1);
    chk("R2", "mode7 wrap", cntVal, 0);

    doReset();
    tick(65535);
    chk("R2", "mode0 full range", cntVal, 16'hFFFF);
    chk("R1", "no overflow below all ones", ovfFlag, 0);
    tick(1);
    chk("R1", "full-width wrap", cntVal, 0);
    chk("R2", "mode0 overflow", ovfFlag, 1);
  endtask

  task automatic testCapTop();
    doReset();
    wr(1, 16'd9);
    wr(0, ctrlWord(4'd14, 2'd0, 2'd0));
    tick(9);
    chk("R2", "mode14 at TOP", cntVal, 9);
    chk("R5", "no capture flag early", capFlag, 0);
    tick(1);
    chk("R2", "mode14 wrap", cntVal, 0);
    chk("R5", "overflow in mode14", ovfFlag, 1);
    chk("R5", "capture flag with overflow", capFlag, 1);
    // W1C of capture flag only
    wr(2, 16'h0002);
    chk("R9", "capture flag cleared", capFlag, 0);
    chk("R9", "overflow untouched", ovfFlag, 1);
    wr(2, 16'h000F);
    tick(3);
    capPulse();
    chk("R10", "capture ignored in mode14", capVal, 9);
    chk("R10", "no capture flag in mode14", capFlag, 0);
    tick(6);
    chk("R9", "counter at TOP", cntVal, 9);
    // clear on the same edge as the set
    @(negedge clk);
    tickEn = 1'b1; busWe = 1'b1; busAddr = 3'd2; busWdata = 16'h0001;
    @(negedge clk);
    tickEn = 1'b0; busWe = 1'b0;
    chk("R9", "set wins over clear", ovfFlag, 1);
    chk("R1", "wrap during clear", cntVal, 0);
    wr(2, 16'h0001);
    chk("R9", "overflow cleared", ovfFlag, 0);
  endtask

  task automatic testCmpTop();
    doReset();
    wr(0, ctrlWord(4'd15, 2'd0, 2'd0));
    wr(4, 16'd5);
    chk("R8", "buffered TOP not yet active", cntVal, 0);
    tick(1);
    chk("R8", "TOP loads at zero TOP", cntVal, 0);
    wr(2, 16'h000F);
    tick(5);
    chk("R2", "mode15 at TOP", cntVal, 5);
    chk("R5", "no overflow before TOP", ovfFlag, 0);
    tick(1);
    chk("R2", "mode15 wrap", cntVal, 0);
    chk("R5", "overflow mode15", ovfFlag, 1);
    chk("R5", "compare A flag with overflow", cmpFlag[0], 1);
  endtask

  task automatic testDuty();
    int h0, h1;
    doReset();
    wr(1, 16'd9);
    wr(0, ctrlWord(4'd14, 2'd2, 2'd3));
    wr(4, 16'd3);
    wr(5, 16'd3);
    tick(10);
    chk("R8", "period done", cntVal, 0);
    measure(10, h0, h1);
    chk("R3", "non-inverting high count", h0, 4);
    chk("R4", "inverting high count", h1, 6);
    // buffering: new value waits for TOP
    tick(1);
    wr(4, 16'd6);
    wr(2, 16'h000F);
    tick(2);
    chk("R6", "no match before 3", cmpFlag[0], 0);
    tick(1);
    chk("R8", "old compare still active", cmpFlag[0], 1);
    tick(6);
    chk("R8", "back at BOTTOM", cntVal, 0);
    measure(10, h0, h1);
    chk("R8", "new duty after TOP", h0, 7);
    // outputs disconnected
    wr(0, ctrlWord(4'd14, 2'd0, 2'd1));
    measure(10, h0, h1);
    chk("R4", "mode0 output low", h0, 0);
    chk("R4", "mode1 output low", h1, 0);
  endtask

  task automatic testEdges();
    int h0, h1;
    doReset();
    wr(1, 16'd9);
    wr(0, ctrlWord(4'd14, 2'd2, 2'd2));
    wr(4, 16'd12);
    wr(5, 16'd0);
    tick(10);
    wr(2, 16'h000F);
    measure(10, h0, h1);
    chk("R6", "compare above TOP stays high", h0, 10);
    chk("R6", "compare above TOP no flag", cmpFlag[0], 0);
    chk("R3", "compare zero single count", h1, 1);
    chk("R6", "compare zero flag", cmpFlag[1], 1);
  endtask

  task automatic testMask();
    doReset();
    wr(0, ctrlWord(4'd5, 2'd0, 2'd0));
    wr(4, 16'h1234);
    tick(256);
    wr(2, 16'h000F);
    tick(16'h34);
    chk("R7", "no match below masked value", cmpFlag[0], 0);
    tick(1);
    chk("R7", "match at masked value", cmpFlag[0], 1);
  endtask

  task automatic testCapture();
    doReset();
    wr(0, ctrlWord(4'd5, 2'd0, 2'd0));
    tick(20);
    capPulse();
    chk("R10", "captured counter", capVal, 20);
    chk("R10", "capture flag", capFlag, 1);
  endtask

  initial begin
    #(8 * 190000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    testReset();
    testFixedTops();
    testCapTop();
    testCmpTop();
    testDuty();
    testEdges();
    testMask();
    testCapture();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule